// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block is a general-purpose I/O port of parameterised width (32 lines by default). Software never has to read, mask and rewrite a latch to change an output. It writes a mask to a set register or to a clear register. Only the lines marked with a 1 in that mask change, so two independent pieces of software cannot overwrite each other's output bits.

The driven values are kept in an output-status register, which software can read back. A separate output-enable register decides which lines actually drive their pads. The levels seen on the pads reach a pin-status register through a two-flop resynchronisation chain. That register reports the real level on every line, whatever the direction of the line and whoever drives it. When the port clock enable is low, the chain stops and the pin-status register keeps the levels it held when the enable dropped.

Access goes through a simple synchronous register bus. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, the output-status register, the output-enable register, `pad_oe`, `pad_out` and the pin-status register are all zero.
- R2: A write to offset 0x04 sets every output-status bit whose mask bit is 1. All other output-status bits keep their previous values.
- R3: A write to offset 0x08 clears every output-status bit whose mask bit is 1. All other output-status bits keep their previous values.
- R4: Offset 0x00 is the output-enable register, which is written and read as a whole word. Offset 0x0C reads the output-status register, which follows set and clear writes whether or not a line is enabled. `pad_oe` equals the output-enable register, and `pad_out` equals output-status AND output-enable.
- R5: Offset 0x10 reads the pin levels, whatever the output-enable setting. While `port_clk_en` is high, a pad value present before clock edge k is visible after edge k+1 and not after edge k alone.
- R6: While `port_clk_en` is low, the pin-status register holds its value whatever `pad_in` does. Tracking resumes, with the same two-edge latency, once the enable returns high.
- R7: Offsets 0x04, 0x08 and every address not listed above (for example 0x01 and 0x14) read as 0. Writes to 0x0C, 0x10 or unlisted addresses change no state.
- R8: A cycle with `bus_we` low changes neither the output-status register nor the output-enable register, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| port_clk_en | input | 1 | Enables the pin resynchronisation chain; low freezes pin status |
| bus_addr | input | ADDR_W (8) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | WIDTH (32) | Write data or mask |
| bus_rdata | output | WIDTH (32) | Read data for `bus_addr` |
| pad_in | input | WIDTH (32) | Levels sampled from the pads |
| pad_out | output | WIDTH (32) | Values driven towards the pads |
| pad_oe | output | WIDTH (32) | Per-line output enable |

## Verification
The bench uses the default parameters: WIDTH=32, ADDR_W=8, SYNC_STAGES=2. The full 32-bit width lets masks reach bit 31 and mix the upper and lower halves, so a mask that covers only one half of the word is checked against the untouched other half. The 8-bit address reaches misaligned and out-of-map offsets such as 0x01 and 0x14. With two synchronizer stages, the exact edge at which a pad change becomes visible can be pinned down, and so can the behaviour when the enable is toggled while the chain still holds an older value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Byte offsets of the port registers
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_DRV  = 8'h0C;
  localparam logic [7:0] OFS_LVL  = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_DRV,
    SEL_LVL
  } port_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);

  always_comb begin
    if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
    else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
    else if (addr == ADDR_W'(OFS_DRV)) sel = SEL_DRV;
    else if (addr == ADDR_W'(OFS_LVL)) sel = SEL_LVL;
    else                               sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_drive_regs.sv
module gpio_drive_regs #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             set_wr,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] drive_q,
  output logic [WIDTH-1:0] dir_q
);

  logic [WIDTH-1:0] drive_d;
  logic [WIDTH-1:0] dir_d;
  logic             drive_en;
  logic             dir_en;

  // Next state: set first, clear applied last so clear wins on overlap
  always_comb begin
    drive_d = drive_q;
    if (set_wr) drive_d = drive_d | wdata;
    if (clr_wr) drive_d = drive_d & ~wdata;
    drive_en = set_wr | clr_wr;
    dir_d    = wdata;
    dir_en   = dir_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= '0;
    end else begin
      if (drive_en) drive_q <= drive_d;
      if (dir_en)   dir_q   <= dir_d;
    end
  end

  assert_set_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && !clr_wr) |=> ((drive_q & $past(wdata)) == $past(wdata)));

  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && !clr_wr) |=> ((drive_q & ~$past(wdata)) == ($past(drive_q) & ~$past(wdata))));

  assert_clr_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((drive_q & $past(wdata)) == '0));

  assert_drive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> $stable(drive_q));

  assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q));

endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] level_q
);

  logic [WIDTH-1:0] stage_q [SYNC_STAGES];
  logic [WIDTH-1:0] stage_d [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = run_en ? pad_in : stage_q[g];
    end else begin : g_next
      always_comb stage_d[g] = run_en ? stage_q[g-1] : stage_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign level_q = stage_q[SYNC_STAGES-1];

  assert_level_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(level_q));

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_clk_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  port_sel_e        sel;
  logic             dir_wr;
  logic             set_wr;
  logic             clr_wr;
  logic [WIDTH-1:0] drive_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] level_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    dir_wr = bus_we && (sel == SEL_DIR);
    set_wr = bus_we && (sel == SEL_SET);
    clr_wr = bus_we && (sel == SEL_CLR);
  end

  gpio_drive_regs #(.WIDTH(WIDTH)) u_drv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dir_wr  (dir_wr),
    .set_wr  (set_wr),
    .clr_wr  (clr_wr),
    .wdata   (bus_wdata),
    .drive_q (drive_q),
    .dir_q   (dir_q)
  );

  gpio_level_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_en  (port_clk_en),
    .pad_in  (pad_in),
    .level_q (level_q)
  );

  always_comb begin
    case (sel)
      SEL_DIR: bus_rdata = dir_q;
      SEL_DRV: bus_rdata = drive_q;
      SEL_LVL: bus_rdata = level_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe  = dir_q;
  assign pad_out = drive_q & dir_q;

  assert_pad_off_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_out & ~pad_oe) == '0));

  assert_wo_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_CLR)) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_setclr_port.sv
module tb_gpio_setclr_port;

  localparam int W = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          port_clk_en;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pad_in;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;

  always #2 clk = ~clk;

  gpio_setclr_port #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .port_clk_en(port_clk_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string phase = "R1";

  // Behavioural reference
  logic [W-1:0] m_drv;
  logic [W-1:0] m_dir;
  logic [W-1:0] m_lvl_q[$];
  int           m_rel;

  function automatic logic [W-1:0] m_read(input logic [AW-1:0] a);
    if (a == 8'h00) return m_dir;
    if (a == 8'h0C) return m_drv;
    if (a == 8'h10) return m_lvl_q[0];
    return '0;
  endfunction

  task automatic check_eq(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    m_drv = '0; m_dir = '0; m_lvl_q = '{'0, '0}; m_rel = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0;
    end else begin
      if (m_rel < 2) begin
        m_drv = '0; m_dir = '0; m_lvl_q = '{'0, '0};
        m_rel++;
      end else begin
        if (bus_we && bus_addr == 8'h00) m_dir = bus_wdata;
        if (bus_we && bus_addr == 8'h04) m_drv = m_drv | bus_wdata;
        if (bus_we && bus_addr == 8'h08) m_drv = m_drv & ~bus_wdata;
        if (port_clk_en) begin
          m_lvl_q.push_back(pad_in);
          void'(m_lvl_q.pop_front());
        end
      end
    end
    #1;
    if (rst_n && m_rel >= 2) begin
      check_eq({phase, " rdata"}, bus_rdata, m_read(bus_addr));
      check_eq({phase, " R4 pad_oe"}, pad_oe, m_dir);
      check_eq({phase, " R4 pad_out"}, pad_out, m_drv & m_dir);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    check_eq(tag, bus_rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; port_clk_en = 1'b1; bus_addr = '0; bus_we = 1'b0;
    bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    phase = "R1";
    rd(8'h0C, '0, "R1 drive reset");
    rd(8'h00, '0, "R1 dir reset");
    rd(8'h10, '0, "R1 level reset");
    check_eq("R1 pad_oe reset", pad_oe, '0);
    check_eq("R1 pad_out reset", pad_out, '0);

    phase = "R4";
    wr(8'h00, 32'hFFFF_0000);
    rd(8'h00, 32'hFFFF_0000, "R4 dir readback");

    phase = "R2";
    wr(8'h04, 32'h0000_00FF);
    rd(8'h0C, 32'h0000_00FF, "R2 set low byte");
    wr(8'h04, 32'h8001_0000);
    rd(8'h0C, 32'h8001_00FF, "R2 set keeps others");
    check_eq("R4 pad_out gated", pad_out, 32'h8001_0000);

    phase = "R3";
    wr(8'h08, 32'h0000_000F);
    rd(8'h0C, 32'h8001_00F0, "R3 clear nibble");
    wr(8'h08, 32'h8000_0000);
    rd(8'h0C, 32'h0001_00F0, "R3 clear top bit");

    phase = "R7";
    rd(8'h04, '0, "R7 set reads zero");
    rd(8'h08, '0, "R7 clr reads zero");
    rd(8'h14, '0, "R7 unmapped reads zero");
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0001_00F0, "R7 drive untouched");
    rd(8'h00, 32'hFFFF_0000, "R7 dir untouched");

    phase = "R8";
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
    @(negedge clk);
    bus_addr = 8'h00;
    @(negedge clk);
    rd(8'h0C, 32'h0001_00F0, "R8 no-strobe drive");
    rd(8'h00, 32'hFFFF_0000, "R8 no-strobe dir");

    phase = "R5";
    rd(8'h10, '0, "R5 level before");
    @(negedge clk);
    pad_in = 32'hA5A5_1234;
    @(posedge clk); #2;
    check_eq("R5 not after one edge", bus_rdata, '0);
    @(posedge clk); #2;
    check_eq("R5 visible after two edges", bus_rdata, 32'hA5A5_1234);

    phase = "R6";
    @(negedge clk);
    port_clk_en = 1'b0;
    pad_in = 32'h0F0F_F0F0;
    repeat (5) @(negedge clk);
    check_eq("R6 frozen", bus_rdata, 32'hA5A5_1234);
    port_clk_en = 1'b1;
    @(posedge clk); #2;
    check_eq("R6 resume one edge", bus_rdata, 32'hA5A5_1234);
    @(posedge clk); #2;
    check_eq("R6 resume two edges", bus_rdata, 32'h0F0F_F0F0);

    phase = "R2/R3/R5 mixed";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      case ($urandom_range(0, 6))
        0: bus_addr = 8'h00;
        1: bus_addr = 8'h04;
        2: bus_addr = 8'h08;
        3: bus_addr = 8'h0C;
        4: bus_addr = 8'h10;
        5: bus_addr = 8'h14;
        default: bus_addr = 8'h04;
      endcase
      bus_we = ($urandom_range(0, 2) != 0);
      bus_wdata = $urandom();
      pad_in = $urandom();
      port_clk_en = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    bus_we = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule